// File: doc/BRIEF.md
# Modulo Counter PWM Channel

This block produces a pulse-width modulated waveform from a single up-counter. The counter runs from zero up to a programmable limit and wraps back to zero; each wrap marks the start of a new period and raises a one-clock overflow strobe. At the wrap the output is driven to its active level. When the counter later equals the programmed compare value, the output returns to its inactive level. The pulse therefore lasts from the wrap to the compare match, and the period is the number of counter states times the prescaler division.

A three-bit divider select slows the counter by a power of two. A polarity input chooses whether the active level is high or low. The limit and compare inputs are captured into internal working registers only at a wrap. Software may change them at any time, and the waveform still changes only on a period boundary.

Top module: `modpwm_channel`

## Requirements
- R1: While reset is asserted and on the first sample after it, the overflow strobe is low and the output sits at its inactive level (low when polarity is 0, high when polarity is 1).
- R2: With the limit register at M and divide-by-1, overflow strobes are exactly M+1 clocks apart, and each strobe is one clock wide.
- R3: Divider select code k for k = 0..6 makes the counter advance once every 2^k clocks, and code 7 acts as code 6 (every 64 clocks), so the period is (M+1)·2^k clocks.
- R4: For a compare value C with 1 ≤ C ≤ M, the output is at its active level for exactly C·2^k clocks per period, beginning in the clock of the overflow strobe.
- R5: Polarity 0 makes the active level high; polarity 1 makes it low. The period is unchanged by polarity.
- R6: A compare value of 0 keeps the output inactive for the whole period. A compare value greater than M keeps it active for the whole period.
- R7: New limit and compare values written during a period leave that period unchanged and take effect from the next overflow.
- R8: A limit of 255 at divide-by-1 gives a period of 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mod_i | input | CNT_W | Counter limit; the counter wraps after reaching it |
| cmp_i | input | CNT_W | Compare value that ends the active pulse |
| psc_sel_i | input | SEL_W | Divider select, power-of-two exponent, clamped to MAX_SHIFT |
| pol_i | input | 1 | Polarity: 0 = active high, 1 = active low |
| pwm_o | output | 1 | PWM output |
| ovf_o | output | 1 | One-clock strobe in the first clock of each period |

## Verification
The bench uses the default parameters: a 16-bit counter, a 3-bit divider select and a largest shift of 6. With a 3-bit select the unused code 7 can be driven, so the clamp to divide-by-64 can be checked. With a 16-bit counter the 255 limit fits, and compare values above the limit can be applied for the full-duty case. Keeping the limits small while sweeping every divider code holds each measured period to at most a few hundred clocks. Periods and active times are counted at the output pin. They are compared with (M+1)·2^k and with the clamped compare product.

// File: rtl/modpwm_pkg.sv
package modpwm_pkg;

   typedef enum logic {
      POL_ACT_HIGH = 1'b0,
      POL_ACT_LOW  = 1'b1
   } pol_e;

   // Clamp a divider select code to the largest supported shift.
   function automatic int unsigned clamp_shift(input int unsigned code,
                                               input int unsigned lim);
      return (code > lim) ? lim : code;
   endfunction

endpackage

// File: rtl/modpwm_prescale.sv
module modpwm_prescale #(
   parameter int SEL_W     = 3,
   parameter int MAX_SHIFT = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   import modpwm_pkg::*;

   if (SEL_W < 1) begin : g_bad_sel
      $error("modpwm_prescale: SEL_W must be at least 1");
   end
   if (MAX_SHIFT < 0 || MAX_SHIFT >= (1 << SEL_W)) begin : g_bad_shift
      $error("modpwm_prescale: MAX_SHIFT must fit in the select code");
   end

   if (MAX_SHIFT == 0) begin : g_nodiv
      // Counter advances on every clock; the select has nothing to choose.
      logic unused_inputs;
      assign unused_inputs = ^{sel_i, clk_i, rst_i};
      assign tick_o = 1'b1;
   end else begin : g_div
      logic [MAX_SHIFT-1:0] div_q;
      logic [MAX_SHIFT-1:0] mask;
      int unsigned          shift;

      always_comb begin
         shift = clamp_shift(32'(sel_i), MAX_SHIFT);
         mask  = MAX_SHIFT'((32'd1 << shift) - 32'd1);
      end

      always_ff @(posedge clk_i) begin
         if (rst_i) div_q <= '0;
         else       div_q <= div_q + {{(MAX_SHIFT-1){1'b0}}, 1'b1};
      end

      assign tick_o = ((div_q & mask) == mask);

      // R3
      tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         (tick_o && sel_i != '0) |=> (!tick_o || sel_i == '0))
         else $error("prescaler ticked on consecutive clocks with a nonzero select");
   end

endmodule

// File: rtl/modpwm_counter.sv
module modpwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] mod_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             wrap_o,
   output logic [CNT_W-1:0] cnt_next_o,
   output logic [CNT_W-1:0] cmp_next_o,
   output logic [CNT_W-1:0] cmp_act_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_w
      $error("modpwm_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mod_q;
   logic [CNT_W-1:0] cmp_q;
   logic             ovf_q;

   assign wrap_o     = tick_i && (cnt_q == mod_q);
   assign cnt_next_o = wrap_o ? '0 : (tick_i ? cnt_q + ONE : cnt_q);
   assign cmp_next_o = wrap_o ? cmp_i : cmp_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         mod_q <= '0;
         cmp_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_next_o;
         ovf_q <= wrap_o;
         if (wrap_o) begin
            mod_q <= mod_i;
            cmp_q <= cmp_i;
         end
      end
   end

   assign cmp_act_o = cmp_q;
   assign ovf_o     = ovf_q;

   // R1
   reset_state_chk: assert property (@(posedge clk_i)
      rst_i |=> (!ovf_q && cnt_q == '0))
      else $error("counter state not cleared by reset");

   // R2
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= mod_q)
      else $error("counter ran past the working limit");

   // R7
   shadow_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !ovf_q |-> ($stable(mod_q) && $stable(cmp_q)))
      else $error("working limit or compare changed away from a period boundary");

endmodule

// File: rtl/modpwm_outstage.sv
module modpwm_outstage #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_next_i,
   input  logic [CNT_W-1:0] cmp_next_i,
   input  logic             pol_i,
   output logic             act_o,
   output logic             pwm_o
);
   import modpwm_pkg::*;

   logic act_q;
   pol_e pol;

   assign pol = pol_e'(pol_i);

   // A compare match wins over the wrap, so compare 0 yields a zero-width pulse.
   always_ff @(posedge clk_i) begin
      if (rst_i)
         act_q <= 1'b0;
      else if (tick_i) begin
         if (cnt_next_i == cmp_next_i) act_q <= 1'b0;
         else if (wrap_i)              act_q <= 1'b1;
      end
   end

   assign act_o = act_q;
   assign pwm_o = (pol == POL_ACT_LOW) ? ~act_q : act_q;

endmodule

// File: rtl/modpwm_channel.sv
module modpwm_channel #(
   parameter int CNT_W     = 16,
   parameter int SEL_W     = 3,
   parameter int MAX_SHIFT = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] mod_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic [SEL_W-1:0] psc_sel_i,
   input  logic             pol_i,
   output logic             pwm_o,
   output logic             ovf_o
);
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] cmp_next;
   logic [CNT_W-1:0] cmp_act;
   logic             act;

   modpwm_prescale #(
      .SEL_W    (SEL_W),
      .MAX_SHIFT(MAX_SHIFT)
   ) u_psc (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .sel_i (psc_sel_i),
      .tick_o(tick)
   );

   modpwm_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tick_i    (tick),
      .mod_i     (mod_i),
      .cmp_i     (cmp_i),
      .wrap_o    (wrap),
      .cnt_next_o(cnt_next),
      .cmp_next_o(cmp_next),
      .cmp_act_o (cmp_act),
      .ovf_o     (ovf_o)
   );

   modpwm_outstage #(
      .CNT_W(CNT_W)
   ) u_out (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tick_i    (tick),
      .wrap_i    (wrap),
      .cnt_next_i(cnt_next),
      .cmp_next_i(cmp_next),
      .pol_i     (pol_i),
      .act_o     (act),
      .pwm_o     (pwm_o)
   );

   // R4
   period_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ovf_o |-> (act == (cmp_act != '0)))
      else $error("output not active at the start of a period with nonzero compare");

   // R1
   reset_level_chk: assert property (@(posedge clk_i)
      rst_i |=> (pwm_o == pol_i))
      else $error("output not at inactive level after reset");

endmodule

// File: tb/tb_modpwm_channel.sv
module tb_modpwm_channel;

   localparam int CNT_W     = 16;
   localparam int SEL_W     = 3;
   localparam int MAX_SHIFT = 6;
   localparam int WD_LIMIT  = 150000;
   localparam int NV        = 12;

   // Vector table: limit, compare, divider code, polarity
   localparam int V_MOD [NV] = '{3, 9, 4, 5, 2, 1, 1, 3, 2, 4, 4, 255};
   localparam int V_CMP [NV] = '{1, 4, 2, 3, 1, 1, 1, 2, 1, 0, 9, 100};
   localparam int V_SEL [NV] = '{0, 0, 1, 2, 3, 6, 7, 4, 5, 0, 0, 0};
   localparam int V_POL [NV] = '{0, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0};

   logic             clk = 1'b0;
   logic             rst;
   logic [CNT_W-1:0] mod_v;
   logic [CNT_W-1:0] cmp_v;
   logic [SEL_W-1:0] sel_v;
   logic             pol_v;
   logic             pwm;
   logic             ovf;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   modpwm_channel #(
      .CNT_W    (CNT_W),
      .SEL_W    (SEL_W),
      .MAX_SHIFT(MAX_SHIFT)
   ) dut (
      .clk_i    (clk),
      .rst_i    (rst),
      .mod_i    (mod_v),
      .cmp_i    (cmp_v),
      .psc_sel_i(sel_v),
      .pol_i    (pol_v),
      .pwm_o    (pwm),
      .ovf_o    (ovf)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD_LIMIT) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // Advance to the next sample where the overflow strobe is high.
   task automatic wait_ovf();
      do @(negedge clk); while (ovf !== 1'b1);
   endtask

   // Starting on an overflow sample, count clocks and active clocks of one period.
   task automatic measure(output int per, output int act);
      per = 0;
      act = 0;
      do begin
         per++;
         if (pwm === ~pol_v) act++;
         @(negedge clk);
      end while (ovf !== 1'b1);
   endtask

   function automatic int exp_period(input int m, input int s);
      int sh = (s > MAX_SHIFT) ? MAX_SHIFT : s;
      return (m + 1) << sh;
   endfunction

   function automatic int exp_active(input int m, input int c, input int s);
      int sh = (s > MAX_SHIFT) ? MAX_SHIFT : s;
      if (c == 0) return 0;
      if (c > m)  return (m + 1) << sh;
      return c << sh;
   endfunction

   initial begin
      int per;
      int act;
      rst   = 1'b1;
      mod_v = '0;
      cmp_v = '0;
      sel_v = '0;
      pol_v = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state, active-high polarity
      chk("R1 ovf in reset", int'(ovf), 0);
      chk("R1 pin in reset pol0", int'(pwm), 0);
      pol_v = 1'b1;
      @(negedge clk);
      // R1 / R5: inactive level follows polarity
      chk("R5 pin in reset pol1", int'(pwm), 1);
      pol_v = 1'b0;
      rst   = 1'b0;

      // Vector walk: R2 period, R3 divider codes, R4 duty, R5 polarity, R6 extremes, R8 full 8-bit
      for (int i = 0; i < NV; i++) begin
         string rp;
         string ra;
         mod_v = CNT_W'(V_MOD[i]);
         cmp_v = CNT_W'(V_CMP[i]);
         sel_v = SEL_W'(V_SEL[i]);
         pol_v = V_POL[i][0];
         wait_ovf();
         measure(per, act);
         if (V_MOD[i] == 255)   rp = $sformatf("R8 period v%0d", i);
         else if (V_SEL[i] > 0) rp = $sformatf("R3 period v%0d", i);
         else                   rp = $sformatf("R2 period v%0d", i);
         if (V_POL[i] != 0)                             ra = $sformatf("R5 active v%0d", i);
         else if (V_CMP[i] == 0 || V_CMP[i] > V_MOD[i]) ra = $sformatf("R6 active v%0d", i);
         else                                           ra = $sformatf("R4 active v%0d", i);
         chk(rp, per, exp_period(V_MOD[i], V_SEL[i]));
         chk(ra, act, exp_active(V_MOD[i], V_CMP[i], V_SEL[i]));
      end

      // R2: strobe is a single clock wide at divide-by-4
      mod_v = 16'd2;
      cmp_v = 16'd1;
      sel_v = 3'd2;
      pol_v = 1'b0;
      wait_ovf();
      wait_ovf();
      @(negedge clk);
      chk("R2 strobe width", int'(ovf), 0);

      // R7: values changed in mid-period only apply from the next overflow
      mod_v = 16'd7;
      cmp_v = 16'd2;
      sel_v = 3'd0;
      wait_ovf();
      wait_ovf();
      mod_v = 16'd3;
      cmp_v = 16'd6;
      measure(per, act);
      chk("R7 old period kept", per, 8);
      chk("R7 old compare kept", act, 2);
      measure(per, act);
      chk("R7 new period", per, 4);
      chk("R7 new compare", act, 4);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule